// File: doc/BRIEF.md
# Inter-core LUT write fabric

This block lets any of sixteen processor cores push a 32-bit word into the local lookup RAM of one or more other cores without passing through shared memory. Each core offers a request made of a valid strobe, a delivery mode, a one-bit-per-core destination mask, a word address and a data word. A single request may name several destinations at once, and every named RAM is written in the same cycle.

Two delivery modes exist. Immediate requests go onto the fabric in the cycle they are presented. When several of them name the same RAM in that cycle, their addresses are ORed together and their data words are ORed together, and the merged word is written at the merged address. There is no arbitration. Slotted requests are captured into a per-core holding register. Each is driven onto the fabric only in the one cycle where a free-running rotating slot counter equals the requesting core's index, so slotted writers never meet.

Every destination RAM has two ports. Port A belongs to the owning core for its own reads and writes. Port B normally serves a streamer read, but a remote write takes port B over for that cycle. There is no path for reading another core's RAM.

Top module: `lut_write_fabric`

## Requirements
- R1: While reset is asserted, the slot counter reads 0, no slotted request is pending, no remote-write flag is set and every streamer valid is low.
- R2: An immediate request (mode bit 0) writes its data at its address in every RAM whose mask bit is set, with bit d of the mask naming core d. The word can be read through that core's port A one clock after the request cycle. RAMs whose mask bit is clear keep their contents.
- R3: When several immediate requests name the same RAM in one cycle, that RAM receives the bitwise OR of their data at the bitwise OR of their addresses.
- R4: The slot counter leaves reset at 0 and advances by one, modulo 16, on every clock.
- R5: A slotted request (mode bit 1) from core i is held pending. It is issued in exactly one cycle: the first cycle in which the slot counter equals i. The pending flag clears after that cycle.
- R6: Slotted requests from different cores that name the same RAM are delivered in different cycles, and each word lands intact at its own address.
- R7: In any cycle where a remote write reaches a RAM, that RAM's streamer read is dropped, and its streamer valid is low in the following cycle. In other cycles, a streamer read returns the stored word with valid high one cycle later.
- R8: If port A and a remote write target the same address of one RAM in the same cycle, the port A data is what remains stored.
- R9: The remote-write flag of destination d is high in exactly those cycles in which a request on the fabric names d.
- R10: A slotted request from a core that already has a slotted request pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_CORES | Request strobe, one bit per source core |
| req_slotted | input | N_CORES | Delivery mode per source: 0 immediate, 1 slotted |
| req_mask | input | N_CORES*N_CORES | Destination masks, source s at bits [s*N_CORES +: N_CORES] |
| req_addr | input | N_CORES*ADDR_W | Word address per source |
| req_data | input | N_CORES*DATA_W | Write data per source |
| pa_en | input | N_CORES | Port A enable per core |
| pa_we | input | N_CORES | Port A write enable per core |
| pa_addr | input | N_CORES*ADDR_W | Port A address per core |
| pa_wdata | input | N_CORES*DATA_W | Port A write data per core |
| pa_rdata | output | N_CORES*DATA_W | Port A read data, one clock after enable |
| sb_en | input | N_CORES | Streamer read request per core |
| sb_addr | input | N_CORES*ADDR_W | Streamer read address per core |
| sb_rdata | output | N_CORES*DATA_W | Streamer read data |
| sb_valid | output | N_CORES | Streamer read data valid |
| rw_hit | output | N_CORES | Remote write applied to this core's RAM this cycle |
| slot_now | output | $clog2(N_CORES) | Current slot number |
| slot_pend | output | N_CORES | Slotted request waiting per source |

## Verification
A remote write and a streamer read can fall on the same RAM in the same cycle. The bench provokes this by keeping a streamer read enabled on one core while an immediate write to that core is presented. It judges the result by a valid gap exactly one cycle after the write, with correct streamer data on both sides of the gap. A local port A write and a remote write can also hit the same word in one cycle. Here the remote-write flag must still rise, and a later port A read must return the local value.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

  // Delivery mode carried with every request.
  typedef enum logic {
    DELIV_NOW  = 1'b0,
    DELIV_SLOT = 1'b1
  } deliv_e;

endpackage

// File: rtl/lwf_slot_seq.sv
module lwf_slot_seq
  import lwf_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_valid,
  input  logic [N-1:0]         req_slotted,
  input  logic [N*N-1:0]       req_mask,
  input  logic [N*AW-1:0]      req_addr,
  input  logic [N*DW-1:0]      req_data,
  output logic [$clog2(N)-1:0] slot,
  output logic [N-1:0]         pend,
  output logic [N-1:0]         fab_valid,
  output logic [N*N-1:0]       fab_mask,
  output logic [N*AW-1:0]      fab_addr,
  output logic [N*DW-1:0]      fab_data
);

  localparam int SW = $clog2(N);

  logic [SW-1:0]   slot_q, slot_d;
  logic [N-1:0]    pend_q, pend_d;
  logic [N-1:0]    issue, take, imm;
  logic [N*N-1:0]  hmask_q;
  logic [N*AW-1:0] haddr_q;
  logic [N*DW-1:0] hdata_q;

  // next-state logic
  always_comb begin
    slot_d = slot_q + 1'b1;
    for (int i = 0; i < N; i++) begin
      issue[i]  = pend_q[i] && (slot_q == SW'(i));
      take[i]   = req_valid[i] && (deliv_e'(req_slotted[i]) == DELIV_SLOT) && !pend_q[i];
      imm[i]    = req_valid[i] && (deliv_e'(req_slotted[i]) == DELIV_NOW) && !issue[i];
      pend_d[i] = take[i] | (pend_q[i] & ~issue[i]);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      pend_q  <= '0;
      hmask_q <= '0;
      haddr_q <= '0;
      hdata_q <= '0;
    end else begin
      slot_q <= slot_d;
      pend_q <= pend_d;
      for (int i = 0; i < N; i++) begin
        if (take[i]) begin
          hmask_q[i*N +: N]   <= req_mask[i*N +: N];
          haddr_q[i*AW +: AW] <= req_addr[i*AW +: AW];
          hdata_q[i*DW +: DW] <= req_data[i*DW +: DW];
        end
      end
    end
  end

  // fabric drive: a slot issue takes the source's lane, else an immediate request
  always_comb begin
    fab_valid = issue | imm;
    fab_mask  = '0;
    fab_addr  = '0;
    fab_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (issue[i]) begin
        fab_mask[i*N +: N]   = hmask_q[i*N +: N];
        fab_addr[i*AW +: AW] = haddr_q[i*AW +: AW];
        fab_data[i*DW +: DW] = hdata_q[i*DW +: DW];
      end else if (imm[i]) begin
        fab_mask[i*N +: N]   = req_mask[i*N +: N];
        fab_addr[i*AW +: AW] = req_addr[i*AW +: AW];
        fab_data[i*DW +: DW] = req_data[i*DW +: DW];
      end
    end
  end

  assign slot = slot_q;
  assign pend = pend_q;

  // R4: counter steps by one every clock
  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_q == SW'($past(slot_q) + 1'b1)));

  // R6: at most one slotted source on the fabric per cycle
  a_r6_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue));

  // R5: an issued request is no longer pending afterwards
  a_r5_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (issue != '0) |=> ((pend_q & $past(issue)) == '0));

  // R10: a pending request stays pending until its slot
  a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(issue)) & ~pend_q) == '0));

endmodule

// File: rtl/lwf_merge.sv
module lwf_merge #(
  parameter int N  = 16,
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic [N-1:0]    fab_valid,
  input  logic [N*N-1:0]  fab_mask,
  input  logic [N*AW-1:0] fab_addr,
  input  logic [N*DW-1:0] fab_data,
  output logic [N-1:0]    hit,
  output logic [N*AW-1:0] wr_addr,
  output logic [N*DW-1:0] wr_data
);

  // Wired-OR of every source that names destination d.
  always_comb begin
    hit     = '0;
    wr_addr = '0;
    wr_data = '0;
    for (int d = 0; d < N; d++) begin
      for (int s = 0; s < N; s++) begin
        if (fab_valid[s] && fab_mask[s*N + d]) begin
          hit[d]               = 1'b1;
          wr_addr[d*AW +: AW] |= fab_addr[s*AW +: AW];
          wr_data[d*DW +: DW] |= fab_data[s*DW +: DW];
        end
      end
    end
  end

endmodule

// File: rtl/lwf_lut_bank.sv
module lwf_lut_bank #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pa_en,
  input  logic          pa_we,
  input  logic [AW-1:0] pa_addr,
  input  logic [DW-1:0] pa_wdata,
  output logic [DW-1:0] pa_rdata,
  input  logic          rw_en,
  input  logic [AW-1:0] rw_addr,
  input  logic [DW-1:0] rw_data,
  input  logic          sb_en,
  input  logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_rdata,
  output logic          sb_valid
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] b_addr;
  logic          b_rd;
  logic [DW-1:0] pa_rdata_q, sb_rdata_q;
  logic          sb_valid_q;

  // port B arbitration: remote write first, streamer read otherwise
  always_comb begin
    b_addr = rw_en ? rw_addr : sb_addr;
    b_rd   = sb_en && !rw_en;
  end

  // storage: port A is written last so it wins a same-address clash
  always_ff @(posedge clk) begin
    if (rw_en)
      mem[b_addr] <= rw_data;
    if (pa_en && pa_we)
      mem[pa_addr] <= pa_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_rdata_q <= '0;
      sb_rdata_q <= '0;
      sb_valid_q <= 1'b0;
    end else begin
      if (pa_en)
        pa_rdata_q <= mem[pa_addr];
      if (b_rd)
        sb_rdata_q <= mem[b_addr];
      sb_valid_q <= b_rd;
    end
  end

  assign pa_rdata = pa_rdata_q;
  assign sb_rdata = sb_rdata_q;
  assign sb_valid = sb_valid_q;

  // R7: a remote write steals the streamer read of that cycle
  a_r7_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_en && sb_en) |=> !sb_valid);

endmodule

// File: rtl/lut_write_fabric.sv
module lut_write_fabric #(
  parameter int N_CORES   = 16,
  parameter int DATA_W    = 32,
  parameter int LUT_DEPTH = 128,
  parameter int ADDR_W    = $clog2(LUT_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CORES-1:0]         req_valid,
  input  logic [N_CORES-1:0]         req_slotted,
  input  logic [N_CORES*N_CORES-1:0] req_mask,
  input  logic [N_CORES*ADDR_W-1:0]  req_addr,
  input  logic [N_CORES*DATA_W-1:0]  req_data,
  input  logic [N_CORES-1:0]         pa_en,
  input  logic [N_CORES-1:0]         pa_we,
  input  logic [N_CORES*ADDR_W-1:0]  pa_addr,
  input  logic [N_CORES*DATA_W-1:0]  pa_wdata,
  output logic [N_CORES*DATA_W-1:0]  pa_rdata,
  input  logic [N_CORES-1:0]         sb_en,
  input  logic [N_CORES*ADDR_W-1:0]  sb_addr,
  output logic [N_CORES*DATA_W-1:0]  sb_rdata,
  output logic [N_CORES-1:0]         sb_valid,
  output logic [N_CORES-1:0]         rw_hit,
  output logic [$clog2(N_CORES)-1:0] slot_now,
  output logic [N_CORES-1:0]         slot_pend
);

  localparam int N  = N_CORES;
  localparam int AW = ADDR_W;
  localparam int DW = DATA_W;

  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic [N-1:0]    fab_valid;
  logic [N*N-1:0]  fab_mask;
  logic [N*AW-1:0] fab_addr;
  logic [N*DW-1:0] fab_data;
  logic [N*AW-1:0] wr_addr;
  logic [N*DW-1:0] wr_data;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  lwf_slot_seq #(.N(N), .AW(AW), .DW(DW)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_slotted(req_slotted),
    .req_mask   (req_mask),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .slot       (slot_now),
    .pend       (slot_pend),
    .fab_valid  (fab_valid),
    .fab_mask   (fab_mask),
    .fab_addr   (fab_addr),
    .fab_data   (fab_data)
  );

  lwf_merge #(.N(N), .AW(AW), .DW(DW)) i_merge (
    .fab_valid(fab_valid),
    .fab_mask (fab_mask),
    .fab_addr (fab_addr),
    .fab_data (fab_data),
    .hit      (rw_hit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  for (genvar g = 0; g < N; g++) begin : g_bank
    lwf_lut_bank #(.DEPTH(LUT_DEPTH), .AW(AW), .DW(DW)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .pa_en   (pa_en[g]),
      .pa_we   (pa_we[g]),
      .pa_addr (pa_addr[g*AW +: AW]),
      .pa_wdata(pa_wdata[g*DW +: DW]),
      .pa_rdata(pa_rdata[g*DW +: DW]),
      .rw_en   (rw_hit[g]),
      .rw_addr (wr_addr[g*AW +: AW]),
      .rw_data (wr_data[g*DW +: DW]),
      .sb_en   (sb_en[g]),
      .sb_addr (sb_addr[g*AW +: AW]),
      .sb_rdata(sb_rdata[g*DW +: DW]),
      .sb_valid(sb_valid[g])
    );
  end

endmodule

// File: tb/test_lut_write_fabric.sv
module test_lut_write_fabric;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int AW = 7;
  localparam int DW = 32;

  typedef struct packed {
    logic [3:0]    src_a;
    logic [N-1:0]  mask_a;
    logic [AW-1:0] addr_a;
    logic [DW-1:0] data_a;
    logic [3:0]    src_b;
    logic [N-1:0]  mask_b;
    logic [AW-1:0] addr_b;
    logic [DW-1:0] data_b;
    logic [3:0]    dst;
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_data;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{4'd0,  16'h0002, 7'h05, 32'h1111_1111, 4'd1,  16'h0000, 7'h00, 32'h0,         4'd1,  7'h05, 32'h1111_1111},
    '{4'd3,  16'h00F0, 7'h0A, 32'hA5A5_0000, 4'd4,  16'h0000, 7'h00, 32'h0,         4'd6,  7'h0A, 32'hA5A5_0000},
    '{4'd2,  16'h0100, 7'h12, 32'h0000_F0F0, 4'd7,  16'h0100, 7'h21, 32'h0F00_000F, 4'd8,  7'h33, 32'h0F00_F0FF},
    '{4'd9,  16'h0600, 7'h03, 32'h0000_0001, 4'd10, 16'h0400, 7'h04, 32'h0000_0002, 4'd9,  7'h03, 32'h0000_0001},
    '{4'd9,  16'h0600, 7'h03, 32'h0000_0001, 4'd10, 16'h0400, 7'h04, 32'h0000_0002, 4'd10, 7'h07, 32'h0000_0003},
    '{4'd15, 16'h8000, 7'h7F, 32'hDEAD_BEEF, 4'd14, 16'h0000, 7'h00, 32'h0,         4'd15, 7'h7F, 32'hDEAD_BEEF},
    '{4'd11, 16'h2000, 7'h41, 32'hFF00_FF00, 4'd12, 16'h3000, 7'h01, 32'h0F0F_0F0F, 4'd13, 7'h41, 32'hFF0F_FF0F}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid, req_slotted;
  logic [N*N-1:0]  req_mask;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_data;
  logic [N-1:0]    pa_en, pa_we;
  logic [N*AW-1:0] pa_addr;
  logic [N*DW-1:0] pa_wdata;
  logic [N*DW-1:0] pa_rdata;
  logic [N-1:0]    sb_en;
  logic [N*AW-1:0] sb_addr;
  logic [N*DW-1:0] sb_rdata;
  logic [N-1:0]    sb_valid;
  logic [N-1:0]    rw_hit;
  logic [3:0]      slot_now;
  logic [N-1:0]    slot_pend;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  lut_write_fabric i_lut_write_fabric (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_slotted(req_slotted), .req_mask(req_mask),
    .req_addr(req_addr), .req_data(req_data),
    .pa_en(pa_en), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pa_rdata(pa_rdata),
    .sb_en(sb_en), .sb_addr(sb_addr), .sb_rdata(sb_rdata), .sb_valid(sb_valid),
    .rw_hit(rw_hit), .slot_now(slot_now), .slot_pend(slot_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_req();
    req_valid = '0; req_slotted = '0; req_mask = '0; req_addr = '0; req_data = '0;
  endtask

  task automatic put_req(input int s, input bit sl, input logic [N-1:0] m,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid[s]          = 1'b1;
    req_slotted[s]        = sl;
    req_mask[s*N +: N]    = m;
    req_addr[s*AW +: AW]  = a;
    req_data[s*DW +: DW]  = d;
  endtask

  task automatic lut_wr(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    pa_en[c] = 1'b1; pa_we[c] = 1'b1;
    pa_addr[c*AW +: AW] = a; pa_wdata[c*DW +: DW] = d;
    @(negedge clk);
    pa_en[c] = 1'b0; pa_we[c] = 1'b0;
  endtask

  task automatic lut_rd(input int c, input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    pa_en[c] = 1'b1; pa_we[c] = 1'b0; pa_addr[c*AW +: AW] = a;
    @(negedge clk);
    d = pa_rdata[c*DW +: DW];
    pa_en[c] = 1'b0;
  endtask

  task automatic wait_slot(input int k);
    do @(negedge clk); while (slot_now != 4'(k));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [3:0]    s0;
    int            nh;
    logic [3:0]    hs;
    rst_n = 1'b0;
    clear_req();
    pa_en = '0; pa_we = '0; pa_addr = '0; pa_wdata = '0;
    sb_en = '0; sb_addr = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 slot", 32'(slot_now), 32'd0);
    check("R1 pend", 32'(slot_pend), 32'd0);
    check("R1 hit", 32'(rw_hit), 32'd0);
    check("R1 sb_valid", 32'(sb_valid), 32'd0);

    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4: counter steps by one, wrapping at 16
    s0 = slot_now;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      check("R4 slot step", 32'(slot_now), 32'(4'(s0 + 4'(k))));
    end

    // preload for the R2 untouched check
    lut_wr(2, 7'h05, 32'h0000_CAFE);

    // table of immediate writes: R2 / R3 / R9
    for (int i = 0; i < NVEC; i++) begin
      logic [N-1:0] tgt;
      int           other;
      @(negedge clk);
      clear_req();
      put_req(VEC[i].src_a, 1'b0, VEC[i].mask_a, VEC[i].addr_a, VEC[i].data_a);
      if (VEC[i].mask_b != '0)
        put_req(VEC[i].src_b, 1'b0, VEC[i].mask_b, VEC[i].addr_b, VEC[i].data_b);
      tgt = VEC[i].mask_a | VEC[i].mask_b;
      other = 0;
      for (int d = N-1; d >= 0; d--) if (!tgt[d]) other = d;
      #1;
      check("R9 hit on target", 32'(rw_hit[VEC[i].dst]), 32'd1);
      check("R9 no hit elsewhere", 32'(rw_hit[other]), 32'd0);
      @(negedge clk);
      clear_req();
      lut_rd(VEC[i].dst, VEC[i].exp_addr, v);
      if (VEC[i].mask_a[VEC[i].dst] && VEC[i].mask_b[VEC[i].dst])
        check("R3 merged write", v, VEC[i].exp_data);
      else
        check("R2 masked write", v, VEC[i].exp_data);
    end

    // R2: unnamed core keeps its word
    lut_rd(2, 7'h05, v);
    check("R2 untouched", v, 32'h0000_CAFE);

    // R5: slotted request waits for its own slot, issues once
    wait_slot(7);
    put_req(5, 1'b1, 16'h0800, 7'h40, 32'h0000_55AA);
    @(negedge clk);
    clear_req();
    check("R5 pending", 32'(slot_pend[5]), 32'd1);
    nh = 0; hs = '0;
    for (int k = 0; k < 20; k++) begin
      if (rw_hit[11]) begin nh++; hs = slot_now; end
      @(negedge clk);
    end
    check("R5 issue count", 32'(nh), 32'd1);
    check("R5 issue slot", 32'(hs), 32'd5);
    check("R5 pend cleared", 32'(slot_pend[5]), 32'd0);
    lut_rd(11, 7'h40, v);
    check("R5 data", v, 32'h0000_55AA);

    // R10: second slotted request while pending is dropped
    lut_wr(11, 7'h41, 32'h0);
    wait_slot(7);
    put_req(5, 1'b1, 16'h0800, 7'h42, 32'h0000_0001);
    @(negedge clk);
    clear_req();
    put_req(5, 1'b1, 16'h0800, 7'h41, 32'h0000_0BAD);
    @(negedge clk);
    clear_req();
    wait_slot(6);
    lut_rd(11, 7'h42, v);
    check("R10 first lands", v, 32'h0000_0001);
    lut_rd(11, 7'h41, v);
    check("R10 second ignored", v, 32'h0);

    // R6: two slotted writers to one RAM do not merge
    lut_wr(12, 7'h30, 32'h0000_0077);
    wait_slot(0);
    put_req(1, 1'b1, 16'h1000, 7'h10, 32'h1111_0000);
    put_req(2, 1'b1, 16'h1000, 7'h20, 32'h0000_2222);
    @(negedge clk);
    clear_req();
    wait_slot(4);
    lut_rd(12, 7'h10, v);
    check("R6 writer 1", v, 32'h1111_0000);
    lut_rd(12, 7'h20, v);
    check("R6 writer 2", v, 32'h0000_2222);
    lut_rd(12, 7'h30, v);
    check("R6 no merged addr", v, 32'h0000_0077);

    // R7: remote write preempts the streamer read
    lut_wr(4, 7'h05, 32'h0000_ABCD);
    @(negedge clk);
    sb_en[4] = 1'b1; sb_addr[4*AW +: AW] = 7'h05;
    @(negedge clk);
    check("R7 valid before", 32'(sb_valid[4]), 32'd1);
    check("R7 data before", sb_rdata[4*DW +: DW], 32'h0000_ABCD);
    put_req(0, 1'b0, 16'h0010, 7'h06, 32'h0000_0099);
    @(negedge clk);
    clear_req();
    check("R7 valid dropped", 32'(sb_valid[4]), 32'd0);
    @(negedge clk);
    check("R7 valid after", 32'(sb_valid[4]), 32'd1);
    check("R7 data after", sb_rdata[4*DW +: DW], 32'h0000_ABCD);
    sb_en[4] = 1'b0;
    lut_rd(4, 7'h06, v);
    check("R7 remote landed", v, 32'h0000_0099);

    // R8: port A beats a remote write to the same word
    @(negedge clk);
    pa_en[6] = 1'b1; pa_we[6] = 1'b1;
    pa_addr[6*AW +: AW] = 7'h09; pa_wdata[6*DW +: DW] = 32'h0000_1234;
    put_req(3, 1'b0, 16'h0040, 7'h09, 32'h0000_FFFF);
    #1;
    check("R9 hit during clash", 32'(rw_hit[6]), 32'd1);
    @(negedge clk);
    clear_req();
    pa_en[6] = 1'b0; pa_we[6] = 1'b0;
    lut_rd(6, 7'h09, v);
    check("R8 port A wins", v, 32'h0000_1234);

    done = 1'b1;
    finish_run();
  end

endmodule